// File: doc/BRIEF.md
# SDRAM Open-Bank Policy Manager

This block lives inside an SDRAM memory controller, between the request queue and the command sequencer. For each accepted access (rank, device bank, row) it decides whether the row is already open, whether a fresh activate is enough, whether the bank must first be precharged, or whether the access must be issued with auto-precharge. It also emits a one-cycle precharge mask that lists banks whose open row the sequencer must close: because an idle timer ran out, because a rank was evicted, or because a bank may no longer be held open.

The number of banks that may be held open is set by an interleave depth (off, two or four). A device option caps it at two banks for older two-bank parts. Two closing policies are selectable. The timer policy lets every bank of every rank keep a row open, and closes a row after a programmable number of idle cycles. The rank-limited policy keeps open rows in at most two ranks. When a third rank needs a row, it precharges every open bank of the less recently used of the two resident ranks.

Top module: `obp_policy_mgr`

## Requirements
- R1: During and directly after reset, no bank holds an open row, `dec_valid` and `pre_mask` are 0 and `req_ready` is 0 while reset is asserted. The first access to any bank therefore reports an activate.
- R2: `req_ready` is 1 from the first clock edge after reset is released. A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `dec_valid` is 1 in exactly the cycle after an accept and carries that request's rank and bank.
- R3: Command codes are 0 hit, 1 activate, 2 precharge-then-activate, 3 activate-with-auto-precharge. An eligible access to a closed bank gives 1. An access to an open bank with the same row gives 0. An access to an open bank with a different row gives 2.
- R4: With `cfg_interleave` = 0 (off), every access gives code 3 and leaves no row open.
- R5: With `cfg_interleave` = 1 (two), only banks 0 and 1 may stay open; accesses to banks 2 and 3 give code 3. Values 2 and 3 of `cfg_interleave` allow four banks.
- R6: With `cfg_two_bank_dev` = 1, banks 2 and 3 give code 3 even at interleave four.
- R7: In the timer policy (`cfg_rank_limit` = 0), a bank left idle after an eligible access has its row closed. The close shows as bit rank*4+bank of `pre_mask` for one cycle, `cfg_idle_cycles` cycles after the decision cycle (a count of 0 behaves as 1).
- R8: Every access to a bank reloads that bank's idle count. A bank accessed at least once every `cfg_idle_cycles` cycles is never closed by the timer.
- R9: In the timer policy, all banks of all ranks may hold open rows at the same time, and nothing closes them except their timers.
- R10: In the rank-limited policy, at most two ranks hold open rows. An eligible access to a third rank sets, in the decision cycle, the `pre_mask` bits of every open bank of the less recently used resident rank, and those banks report activate on their next access.
- R11: An ineligible access to a bank that still holds an open row (after the interleave setting was lowered) gives code 3 and sets that bank's `pre_mask` bit in the decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interleave | input | 2 | Open-bank depth: 0 off, 1 two banks, 2 or 3 four banks |
| cfg_rank_limit | input | 1 | 0 idle-timer policy, 1 two-rank limit policy |
| cfg_two_bank_dev | input | 1 | Devices have only two internal banks |
| cfg_idle_cycles | input | TMR_W | Idle cycles before a timer close |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_rank | input | RANK_W | Target rank |
| req_bank | input | BANK_W | Target device bank |
| req_row | input | ROW_W | Target row |
| dec_valid | output | 1 | Decision present |
| dec_cmd | output | 2 | Decision code (see R3) |
| dec_rank | output | RANK_W | Rank of the decided request |
| dec_bank | output | BANK_W | Bank of the decided request |
| pre_mask | output | NUM_RANKS*NUM_BANKS | Banks to precharge, bit rank*NUM_BANKS+bank |

## Verification
The embedded assertions check on every cycle that decisions follow accepts by exactly one cycle and that interleave-off and upper-bank accesses resolve to auto-precharge. They also check that the precharge mask only names banks that were open, that an open bank in the timer policy always has a live count, and that no more than two ranks are resident under the rank limit. Timer expiry instants, reload behaviour, LRU victim choice and the hit/miss classification depend on request history. Only the bench's reference model can show these, by running directed sequences and pseudo-random streams under each configuration.

// File: rtl/obp_pkg.sv
package obp_pkg;

    typedef enum logic [1:0] {
        CMD_HIT     = 2'd0,
        CMD_ACT     = 2'd1,
        CMD_PRE_ACT = 2'd2,
        CMD_ACT_AP  = 2'd3
    } obp_cmd_e;

    typedef enum logic [1:0] {
        IL_OFF  = 2'd0,
        IL_TWO  = 2'd1,
        IL_FOUR = 2'd2,
        IL_ALT  = 2'd3
    } obp_il_e;

    // Number of low-numbered banks that may keep a row open.
    function automatic int unsigned open_depth(input logic [1:0] il,
                                               input logic       two_bank,
                                               input int unsigned nbanks);
        int unsigned d;
        case (il)
            IL_OFF:  d = 0;
            IL_TWO:  d = 2;
            default: d = 4;
        endcase
        if (two_bank && d > 2) d = 2;
        if (d > nbanks) d = nbanks;
        return d;
    endfunction

endpackage

// File: rtl/obp_bank_slot.sv
module obp_bank_slot #(
    parameter int ROW_W = 14,
    parameter int TMR_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             timer_en,
    input  logic [TMR_W-1:0] idle_cycles,
    input  logic             hit_sel,
    input  logic             keep,
    input  logic [ROW_W-1:0] new_row,
    input  logic             evict,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             expire
);
    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] load_val;
    logic             armed;

    assign load_val = (idle_cycles == '0) ? TMR_W'(1) : idle_cycles;
    assign armed    = is_open && timer_en && !hit_sel;
    assign expire   = armed && (cnt_q == TMR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open  <= 1'b0;
            open_row <= '0;
            cnt_q    <= '0;
        end else if (hit_sel) begin
            is_open  <= keep;
            open_row <= new_row;
            cnt_q    <= load_val;
        end else if (evict || expire) begin
            is_open  <= 1'b0;
        end else if (armed) begin
            cnt_q    <= cnt_q - TMR_W'(1);
        end
    end

    // R7
    timer_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (is_open && timer_en) |-> (cnt_q != '0));

endmodule

// File: rtl/obp_rank_guard.sv
module obp_rank_guard #(
    parameter int NUM_RANKS = 4,
    parameter int RANK_W    = 2,
    parameter int RANK_CAP  = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [NUM_RANKS-1:0] rank_open,
    input  logic                 touch,
    input  logic [RANK_W-1:0]    touch_rank,
    output logic                 evict,
    output logic [RANK_W-1:0]    victim
);
    logic [RANK_W-1:0] mru_q;
    logic              full;

    assign full  = ($countones(rank_open) >= RANK_CAP);
    assign evict = enable && touch && !rank_open[touch_rank] && full;

    // With the cap at two, the resident rank that is not the most
    // recently touched one is the least recently used.
    always_comb begin
        victim = '0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            if (rank_open[r] && (RANK_W'(r) != mru_q)) victim = RANK_W'(r);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        mru_q <= '0;
        else if (touch) mru_q <= touch_rank;
    end

    // R10
    rank_cap_chk: assert property (@(posedge clk) disable iff (rst)
        enable |-> ($countones(rank_open) <= RANK_CAP));

endmodule

// File: rtl/obp_policy_mgr.sv
module obp_policy_mgr #(
    parameter int NUM_RANKS = 4,
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 14,
    parameter int TMR_W     = 12,
    parameter int RANK_W    = $clog2(NUM_RANKS),
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [1:0]                     cfg_interleave,
    input  logic                           cfg_rank_limit,
    input  logic                           cfg_two_bank_dev,
    input  logic [TMR_W-1:0]               cfg_idle_cycles,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [RANK_W-1:0]              req_rank,
    input  logic [BANK_W-1:0]              req_bank,
    input  logic [ROW_W-1:0]               req_row,
    output logic                           dec_valid,
    output logic [1:0]                     dec_cmd,
    output logic [RANK_W-1:0]              dec_rank,
    output logic [BANK_W-1:0]              dec_bank,
    output logic [NUM_RANKS*NUM_BANKS-1:0] pre_mask
);
    import obp_pkg::*;

    localparam int SLOTS  = NUM_RANKS * NUM_BANKS;
    localparam int SLOT_W = $clog2(SLOTS);

    logic              acc;
    logic              keep_ok;
    logic [SLOT_W-1:0] acc_idx;
    logic [SLOTS-1:0]  open_vec;
    logic [SLOTS-1:0]  expire_vec;
    logic [SLOTS-1:0]  evict_mask;
    logic [SLOTS-1:0]  drop_mask;
    logic [SLOTS-1:0]  pre_next;
    logic [ROW_W-1:0]  row_arr [SLOTS];
    logic [NUM_RANKS-1:0] rank_open;
    logic              evict;
    logic [RANK_W-1:0] victim;
    logic              cur_open;
    obp_cmd_e          cmd_next;

    assign acc     = req_valid && req_ready;
    assign acc_idx = SLOT_W'(int'(req_rank) * NUM_BANKS + int'(req_bank));
    assign keep_ok = (int'(req_bank) <
                      int'(open_depth(cfg_interleave, cfg_two_bank_dev, NUM_BANKS)));

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        obp_bank_slot #(.ROW_W(ROW_W), .TMR_W(TMR_W)) u_slot (
            .clk         (clk),
            .rst         (rst),
            .timer_en    (!cfg_rank_limit),
            .idle_cycles (cfg_idle_cycles),
            .hit_sel     (acc && (acc_idx == SLOT_W'(g))),
            .keep        (keep_ok),
            .new_row     (req_row),
            .evict       (evict_mask[g]),
            .is_open     (open_vec[g]),
            .open_row    (row_arr[g]),
            .expire      (expire_vec[g])
        );
        assign evict_mask[g] = evict && open_vec[g] &&
                               (victim == RANK_W'(g / NUM_BANKS));
    end

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        assign rank_open[r] = |open_vec[r*NUM_BANKS +: NUM_BANKS];
    end

    obp_rank_guard #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W), .RANK_CAP(2)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg_rank_limit),
        .rank_open  (rank_open),
        .touch      (acc && keep_ok),
        .touch_rank (req_rank),
        .evict      (evict),
        .victim     (victim)
    );

    assign cur_open = open_vec[acc_idx];

    always_comb begin
        if (!keep_ok)                         cmd_next = CMD_ACT_AP;
        else if (!cur_open)                   cmd_next = CMD_ACT;
        else if (row_arr[acc_idx] == req_row) cmd_next = CMD_HIT;
        else                                  cmd_next = CMD_PRE_ACT;
    end

    always_comb begin
        drop_mask = '0;
        if (acc && !keep_ok && cur_open) drop_mask[acc_idx] = 1'b1;
    end

    assign pre_next = expire_vec | evict_mask | drop_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_ready <= 1'b0;
            dec_valid <= 1'b0;
            dec_cmd   <= CMD_HIT;
            dec_rank  <= '0;
            dec_bank  <= '0;
            pre_mask  <= '0;
        end else begin
            req_ready <= 1'b1;
            dec_valid <= acc;
            pre_mask  <= pre_next;
            if (acc) begin
                dec_cmd  <= cmd_next;
                dec_rank <= req_rank;
                dec_bank <= req_bank;
            end
        end
    end

    // R2
    dec_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> dec_valid);
    // R2
    dec_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !dec_valid);
    // R4
    il_off_autopre_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cfg_interleave == IL_OFF) |=> (dec_cmd == CMD_ACT_AP));
    // R5
    il_two_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && cfg_interleave == IL_TWO && int'(req_bank) >= 2) |=> (dec_cmd == CMD_ACT_AP));
    // R7
    pre_only_open_chk: assert property (@(posedge clk) disable iff (rst)
        ((pre_mask & ~$past(open_vec)) == '0));

endmodule

// File: tb/test_obp_policy_mgr.sv
module test_obp_policy_mgr;
    localparam int NR = 4;
    localparam int NB = 4;
    localparam int NS = NR * NB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_interleave = 2'd2;
    logic        cfg_rank_limit = 1'b0;
    logic        cfg_two_bank_dev = 1'b0;
    logic [11:0] cfg_idle_cycles = 12'd20;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_rank = '0;
    logic [1:0]  req_bank = '0;
    logic [13:0] req_row = '0;
    logic        dec_valid;
    logic [1:0]  dec_cmd;
    logic [1:0]  dec_rank;
    logic [1:0]  dec_bank;
    logic [NS-1:0] pre_mask;

    obp_policy_mgr i_obp_policy_mgr (
        .clk(clk), .rst(rst), .cfg_interleave(cfg_interleave),
        .cfg_rank_limit(cfg_rank_limit), .cfg_two_bank_dev(cfg_two_bank_dev),
        .cfg_idle_cycles(cfg_idle_cycles), .req_valid(req_valid), .req_ready(req_ready),
        .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row),
        .dec_valid(dec_valid), .dec_cmd(dec_cmd), .dec_rank(dec_rank),
        .dec_bank(dec_bank), .pre_mask(pre_mask)
    );

    always #2ns clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    bit     m_open [NS];
    int     m_row  [NS];
    int     m_cnt  [NS];
    longint m_use  [NR];
    longint stamp = 0;
    bit     cur_ready = 0;
    int     e_ready = 0, e_dvalid = 0, e_cmd = 0, e_rank = 0, e_bank = 0, e_pre = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(string t, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    task automatic compare();
        check("R2", "req_ready", int'(req_ready), e_ready);
        check("R2", "dec_valid", int'(dec_valid), e_dvalid);
        if (e_dvalid != 0) begin
            check(tag, "dec_cmd", int'(dec_cmd), e_cmd);
            check("R2", "dec_rank", int'(dec_rank), e_rank);
            check("R2", "dec_bank", int'(dec_bank), e_bank);
        end
        check(tag, "pre_mask", int'(pre_mask), e_pre);
    endtask

    function automatic int ranks_open(output int cnt);
        int mask = 0;
        cnt = 0;
        for (int r = 0; r < NR; r++) begin
            bit any = 0;
            for (int b = 0; b < NB; b++) if (m_open[r*NB+b]) any = 1;
            if (any) begin mask |= (1 << r); cnt++; end
        end
        return mask;
    endfunction

    task automatic model_step(bit v, int rk, int bk, int rw);
        bit acc = v && cur_ready;
        int depth, idx, npre, cnt, rmask, lim;
        bit keep;
        npre = 0;
        depth = (cfg_interleave == 0) ? 0 : (cfg_interleave == 1) ? 2 : 4;
        if (cfg_two_bank_dev && depth > 2) depth = 2;
        keep = (bk < depth);
        idx = rk * NB + bk;
        e_dvalid = acc;
        if (acc) begin
            e_rank = rk;
            e_bank = bk;
            if (!keep) begin
                e_cmd = 3;
                if (m_open[idx]) npre |= (1 << idx);
            end else if (!m_open[idx]) e_cmd = 1;
            else if (m_row[idx] == rw) e_cmd = 0;
            else e_cmd = 2;
            rmask = ranks_open(cnt);
            if (cfg_rank_limit && keep && !rmask[rk] && cnt >= 2) begin
                int vic = -1;
                for (int r = 0; r < NR; r++)
                    if (rmask[r] && (vic < 0 || m_use[r] < m_use[vic])) vic = r;
                for (int b = 0; b < NB; b++)
                    if (m_open[vic*NB+b]) begin
                        npre |= (1 << (vic*NB+b));
                        m_open[vic*NB+b] = 0;
                    end
            end
        end
        if (!cfg_rank_limit) begin
            for (int i = 0; i < NS; i++) begin
                if (acc && i == idx) continue;
                if (m_open[i]) begin
                    if (m_cnt[i] == 1) begin m_open[i] = 0; npre |= (1 << i); end
                    else m_cnt[i]--;
                end
            end
        end
        if (acc) begin
            lim = (cfg_idle_cycles == 0) ? 1 : int'(cfg_idle_cycles);
            m_open[idx] = keep;
            m_row[idx] = rw;
            m_cnt[idx] = lim;
            if (keep) begin stamp++; m_use[rk] = stamp; end
        end
        e_pre = npre;
        cur_ready = 1;
        e_ready = 1;
    endtask

    task automatic cycle(bit v, int rk, int bk, int rw);
        @(negedge clk);
        compare();
        req_valid = v;
        req_rank = 2'(rk);
        req_bank = 2'(bk);
        req_row = 14'(rw);
        model_step(v, rk, bk, rw);
    endtask

    task automatic idle(int n);
        repeat (n) cycle(0, 0, 0, 0);
    endtask

    task automatic do_reset(int il, bit rl, bit tb2, int lim);
        @(negedge clk);
        rst = 1;
        req_valid = 0;
        cfg_interleave = 2'(il);
        cfg_rank_limit = rl;
        cfg_two_bank_dev = tb2;
        cfg_idle_cycles = 12'(lim);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset req_ready", int'(req_ready), 0);
        check("R1", "reset dec_valid", int'(dec_valid), 0);
        check("R1", "reset pre_mask", int'(pre_mask), 0);
        for (int i = 0; i < NS; i++) begin m_open[i] = 0; m_cnt[i] = 0; m_row[i] = 0; end
        for (int r = 0; r < NR; r++) m_use[r] = 0;
        cur_ready = 0;
        rst = 0;
        model_step(0, 0, 0, 0);
    endtask

    task automatic rand_run(int n);
        for (int k = 0; k < n; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[1:0] != 2'b00, int'(lfsr[3:2]), int'(lfsr[5:4]), int'(lfsr[7:6]));
        end
    endtask

    initial begin
        // R1 / R3: first accesses after reset activate; hit and row change
        do_reset(2, 0, 0, 200);
        tag = "R1";
        cycle(1, 0, 0, 5);
        tag = "R3";
        cycle(1, 0, 0, 5);
        cycle(1, 0, 0, 6);
        cycle(1, 0, 0, 6);
        cycle(0, 0, 0, 0);
        cycle(1, 2, 1, 9);
        idle(2);
        // R9: every bank of every rank open together
        tag = "R9";
        for (int i = 0; i < NS; i++) cycle(1, i / NB, i % NB, 100 + i);
        for (int i = 0; i < NS; i++) cycle(1, i / NB, i % NB, 100 + i);
        idle(3);

        // R7: idle expiry
        do_reset(2, 0, 0, 5);
        tag = "R7";
        cycle(1, 1, 2, 7);
        idle(8);
        cycle(1, 1, 2, 7);
        idle(2);
        // R8: reload keeps the row open
        tag = "R8";
        cycle(1, 3, 3, 4);
        idle(3);
        cycle(1, 3, 3, 4);
        idle(3);
        cycle(1, 3, 3, 4);
        idle(7);
        cfg_idle_cycles = 12'd0;
        tag = "R7";
        cycle(1, 0, 1, 2);
        idle(3);

        // R4: interleave off
        do_reset(0, 0, 0, 20);
        tag = "R4";
        cycle(1, 0, 0, 1);
        cycle(1, 0, 0, 1);
        cycle(1, 1, 3, 2);
        idle(2);

        // R5: interleave two
        do_reset(1, 0, 0, 20);
        tag = "R5";
        for (int b = 0; b < NB; b++) cycle(1, 2, b, 3);
        for (int b = 0; b < NB; b++) cycle(1, 2, b, 3);
        idle(2);

        // R6: two-bank devices
        do_reset(2, 0, 1, 20);
        tag = "R6";
        for (int b = 0; b < NB; b++) cycle(1, 1, b, 8);
        for (int b = 0; b < NB; b++) cycle(1, 1, b, 8);
        idle(2);

        // R11: lower interleave with a row open in bank 2
        do_reset(2, 0, 0, 50);
        tag = "R11";
        cycle(1, 0, 2, 11);
        cycle(1, 0, 0, 12);
        idle(1);
        cfg_interleave = 2'd1;
        cycle(1, 0, 2, 11);
        cycle(1, 0, 0, 12);
        idle(2);

        // R9: random timer-policy stream
        do_reset(2, 0, 0, 6);
        tag = "R9";
        rand_run(300);

        // R10: rank limit and LRU eviction
        do_reset(3, 1, 0, 20);
        tag = "R10";
        cycle(1, 0, 0, 1);
        cycle(1, 1, 0, 2);
        cycle(1, 1, 1, 3);
        cycle(1, 0, 0, 1);
        cycle(1, 2, 3, 4);
        cycle(1, 1, 0, 2);
        cycle(1, 3, 2, 5);
        cycle(1, 1, 1, 3);
        idle(2);
        rand_run(300);
        idle(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #700us;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule